// File: doc/BRIEF.md
# Register-Mapped Serial Port with Transmit and Receive Queues

This block is an asynchronous serial port (8 data bits, no parity, one stop bit) reached through a simple 32-bit register bus. Software writes bytes to a holding register. The bytes wait in a 32-entry transmit queue and are shifted out LSB first. Incoming frames are sampled on a 16x oversampling tick and the good bytes collect in a 32-entry receive queue. Software drains that queue through the data register.

A 10-bit integer divisor makes the oversampling tick. Line faults are latched in sticky status bits that software clears by writing ones: overrun, framing error and break. One level interrupt combines each status source with its enable bit in the control register. The same control register holds a hold-the-line-low request, two queue flush strobes and a soft reset strobe.

Top module: `serial_port_ctrl`

## Requirements
- R1: Byte offsets are 0x00 receive data, 0x04 transmit holding, 0x08 control, 0x0C status and 0x10 divisor. Other offsets read 0. After reset, control and divisor read 0, status reads 0x2060, irq is 0 and txd is 1.
- R2: Divisor bits 9:0 are stored and read back; the upper bits read 0. The tick fires once every divisor clocks. A divisor of 0 stops the tick, so nothing is sent or received.
- R3: Each queued byte leaves in queue order as a low start bit, 8 data bits LSB first and a high stop bit. Every bit lasts 16 ticks. The line rests high.
- R4: The transmit queue holds 32 bytes, and a write while it is full is dropped. The status bits are: 13 = queue empty, 11 = queue full, 6 = queue empty and shifter idle, 5 = queue not full.
- R5: A frame with a high stop bit puts its byte into the receive queue. Status bit 4 reads 1 while the queue is not empty. A read at 0x00 returns the oldest byte in bits 7:0 and removes it. When the queue is empty the read returns 0.
- R6: A good frame that arrives while the receive queue holds 32 bytes is discarded and sets status bit 0 (overrun).
- R7: A frame whose stop bit is low and whose data is not all zero sets status bit 2 (framing). Its byte is not stored.
- R8: A frame whose data and stop bit are all low sets status bit 3 (break). Its byte is not stored. Status bit 1 always reads 0.
- R9: Writing 1 to any of status bits 3:0 clears that bit. Writing 0 leaves it set.
- R10: irq is the OR of the pairs (control bit k AND status bit k) for k in 0..5. Control bits 3:0 enable the error bits, bit 4 enables receive-ready and bit 5 enables transmit-ready.
- R11: While control bit 11 is 1, txd is held at 0.
- R12: Writing control bit 15 empties the transmit queue and writing bit 14 empties the receive queue, each within one cycle. Neither bit is stored: both read 0, and the other written control bits are stored.
- R13: Writing control bit 31 clears control and status bits 3:0 and empties both queues. It does not change the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_sel | input | 1 | access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | byte offset |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, combinational from bus_addr |
| rxd | input | 1 | serial input |
| txd | output | 1 | serial output |
| irq | output | 1 | level interrupt |

## Verification
The transmitter is tried three ways: with a short burst of unlike bytes, with 33 writes while the tick is stopped, and with a queue flush. The burst shows bit order and bit timing. The 33 writes separate a 32-deep queue from a dropping one, and the flush separates a one-cycle clear from a slow drain. The receiver gets three kinds of input. Clean frames with alternating and all-zero patterns check the data path. A run of 33 frames checks overrun and the last-byte discard. Frames with a low stop bit, once with nonzero data and once held low, tell framing apart from break. The interrupt, write-one-to-clear and soft-reset checks are made against the status that the bench predicts.

// File: rtl/sercore_pkg.sv
package sercore_pkg;
  // byte offsets on the register bus
  localparam int unsigned ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFF_RXD  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_TXH  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_STAT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_DIV  = 5'h10;

  // control bit positions
  localparam int unsigned C_SOFT  = 31;
  localparam int unsigned C_TXCLR = 15;
  localparam int unsigned C_RXCLR = 14;
  localparam int unsigned C_BRK   = 11;
  // stored control bits: break request and interrupt enables 5:0
  localparam logic [31:0] CTRL_KEEP = 32'h0000_083F;

  // status bit positions
  localparam int unsigned S_TXE  = 13;
  localparam int unsigned S_TXF  = 11;
  localparam int unsigned S_TXI  = 6;
  localparam int unsigned S_TXR  = 5;
  localparam int unsigned S_RXR  = 4;

  typedef enum logic [2:0] {
    RX_HUNT, RX_START, RX_DATA, RX_STOP, RX_WAIT
  } rx_state_t;

  // assemble the status word
  function automatic logic [31:0] pack_status(input logic txe, input logic txf,
                                              input logic txi, input logic rxr,
                                              input logic [3:0] err);
    logic [31:0] s;
    s        = '0;
    s[S_TXE] = txe;
    s[S_TXF] = txf;
    s[S_TXI] = txi;
    s[S_TXR] = ~txf;
    s[S_RXR] = rxr;
    s[3:0]   = err;
    return s;
  endfunction

  // interrupt: enable bit k gates status bit k for k = 0..5
  function automatic logic irq_any(input logic [31:0] ctrl, input logic [31:0] stat);
    return |(ctrl[5:0] & stat[5:0]);
  endfunction
endpackage

// File: rtl/sercore_fifo.sv
module sercore_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           push,
  input  logic [W-1:0]                   din,
  input  logic                           pop,
  output logic [W-1:0]                   dout,
  output logic                           empty,
  output logic                           full,
  output logic [$clog2(DEPTH+1)-1:0]     level
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];
  assign level   = cnt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sercore_tick.sv
module sercore_tick #(
  parameter int unsigned DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt;

  assign tick = (div != '0) && (cnt == div - DW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (restart || div == '0)    cnt <= '0;
    else if (tick)                    cnt <= '0;
    else                              cnt <= cnt + DW'(1);
  end
endmodule

// File: rtl/sercore_tx.sv
module sercore_tx #(
  parameter int unsigned OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       tick,
  input  logic       q_empty,
  input  logic [7:0] q_data,
  output logic       pop,
  output logic       line,
  output logic       busy
);
  localparam int unsigned OW = $clog2(OS);

  logic [9:0]    frame;
  logic [3:0]    bitn;
  logic [OW-1:0] sub;

  assign pop  = tick && !busy && !q_empty;
  assign line = frame[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; frame <= '1; bitn <= '0; sub <= '0;
    end else if (restart) begin
      busy <= 1'b0; frame <= '1; bitn <= '0; sub <= '0;
    end else if (pop) begin
      busy  <= 1'b1;
      frame <= {1'b1, q_data, 1'b0};
      bitn  <= '0;
      sub   <= '0;
    end else if (busy && tick) begin
      if (sub == OW'(OS-1)) begin
        sub <= '0;
        if (bitn == 4'd9) begin
          busy  <= 1'b0;
          frame <= '1;
        end else begin
          frame <= {1'b1, frame[9:1]};
          bitn  <= bitn + 4'd1;
        end
      end else begin
        sub <= sub + OW'(1);
      end
    end
  end
endmodule

// File: rtl/sercore_rx.sv
module sercore_rx
  import sercore_pkg::*;
#(
  parameter int unsigned OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       tick,
  input  logic       rxd_s,
  output logic       push,
  output logic [7:0] data,
  output logic       ferr,
  output logic       brk
);
  localparam int unsigned OW   = $clog2(OS);
  localparam int unsigned HALF = OS / 2;

  rx_state_t     st;
  logic [OW-1:0] sub;
  logic [2:0]    bitn;
  logic [7:0]    shreg;
  logic          at_end;

  assign at_end = tick && (st == RX_STOP) && (sub == OW'(OS-1));
  assign push   = at_end && rxd_s;
  assign brk    = at_end && !rxd_s && (shreg == 8'h00);
  assign ferr   = at_end && !rxd_s && (shreg != 8'h00);
  assign data   = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_HUNT; sub <= '0; bitn <= '0; shreg <= '0;
    end else if (restart) begin
      st <= RX_HUNT; sub <= '0; bitn <= '0; shreg <= '0;
    end else if (tick) begin
      case (st)
        RX_HUNT: if (!rxd_s) begin st <= RX_START; sub <= '0; end
        RX_START: begin
          if (sub == OW'(HALF-1)) begin
            sub <= '0; bitn <= '0;
            st  <= rxd_s ? RX_HUNT : RX_DATA;
          end else sub <= sub + OW'(1);
        end
        RX_DATA: begin
          if (sub == OW'(OS-1)) begin
            sub   <= '0;
            shreg <= {rxd_s, shreg[7:1]};
            if (bitn == 3'd7) st <= RX_STOP;
            else              bitn <= bitn + 3'd1;
          end else sub <= sub + OW'(1);
        end
        RX_STOP: begin
          if (sub == OW'(OS-1)) begin
            sub <= '0;
            st  <= rxd_s ? RX_HUNT : RX_WAIT;
          end else sub <= sub + OW'(1);
        end
        RX_WAIT: if (rxd_s) st <= RX_HUNT;
        default: st <= RX_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/serial_port_ctrl.sv
module serial_port_ctrl
  import sercore_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned DIV_W      = 10,
  parameter int unsigned OVS        = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                rxd,
  output logic                txd,
  output logic                irq
);
  localparam int unsigned LW = $clog2(FIFO_DEPTH+1);

  logic [31:0]      ctrl_q;
  logic [3:0]       err_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       rx_sync;

  // named internal events
  logic wr, rd, wr_ctrl, wr_stat, wr_div;
  logic soft_rst, tx_clr, rx_clr, brk_on;
  logic tick;
  logic tx_push, tx_pop, tx_empty, tx_full, tx_busy, tx_line;
  logic rx_push, rx_pop, rx_empty, rx_full, rx_ferr, rx_brk;
  logic [7:0] tx_head, rx_head, rx_byte;
  logic [LW-1:0] tx_level, rx_level;
  logic [3:0] err_set, err_w1c;
  logic [31:0] stat_w;

  assign wr       = bus_sel && bus_we;
  assign rd       = bus_sel && !bus_we;
  assign wr_ctrl  = wr && (bus_addr == OFF_CTRL);
  assign wr_stat  = wr && (bus_addr == OFF_STAT);
  assign wr_div   = wr && (bus_addr == OFF_DIV);
  assign soft_rst = wr_ctrl && bus_wdata[C_SOFT];
  assign tx_clr   = soft_rst || (wr_ctrl && bus_wdata[C_TXCLR]);
  assign rx_clr   = soft_rst || (wr_ctrl && bus_wdata[C_RXCLR]);
  assign brk_on   = ctrl_q[C_BRK];
  assign tx_push  = wr && (bus_addr == OFF_TXH);
  assign rx_pop   = rd && (bus_addr == OFF_RXD);

  // sticky error sources: break, framing, parity (never in 8N1), overrun
  assign err_set  = {rx_brk, rx_ferr, 1'b0, rx_push && rx_full};
  assign err_w1c  = wr_stat ? bus_wdata[3:0] : 4'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      err_q   <= '0;
      div_q   <= '0;
      rx_sync <= 2'b11;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      if (wr_div) div_q <= bus_wdata[DIV_W-1:0];
      if (soft_rst) begin
        ctrl_q <= '0;
        err_q  <= '0;
      end else begin
        if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP;
        err_q <= (err_q & ~err_w1c) | err_set;
      end
    end
  end

  sercore_tick #(.DW(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(soft_rst || wr_div), .div(div_q), .tick(tick)
  );

  sercore_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_head), .empty(tx_empty), .full(tx_full), .level(tx_level)
  );

  sercore_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push), .din(rx_byte),
    .pop(rx_pop), .dout(rx_head), .empty(rx_empty), .full(rx_full), .level(rx_level)
  );

  sercore_tx #(.OS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .restart(soft_rst), .tick(tick), .q_empty(tx_empty),
    .q_data(tx_head), .pop(tx_pop), .line(tx_line), .busy(tx_busy)
  );

  sercore_rx #(.OS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .restart(soft_rst), .tick(tick), .rxd_s(rx_sync[1]),
    .push(rx_push), .data(rx_byte), .ferr(rx_ferr), .brk(rx_brk)
  );

  assign stat_w = pack_status(tx_empty, tx_full, tx_empty && !tx_busy, !rx_empty, err_q);
  assign txd    = brk_on ? 1'b0 : tx_line;
  assign irq    = irq_any(ctrl_q, stat_w);

  always_comb begin
    case (bus_addr)
      OFF_RXD:  bus_rdata = rx_empty ? 32'h0 : {24'h0, rx_head};
      OFF_CTRL: bus_rdata = ctrl_q;
      OFF_STAT: bus_rdata = stat_w;
      OFF_DIV:  bus_rdata = {{(32-DIV_W){1'b0}}, div_q};
      default:  bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/serial_port_ctrl_chk.sv
module serial_port_ctrl_chk #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DIVW  = 10
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         tick,
  input logic [DIVW-1:0]              div_q,
  input logic                         txd,
  input logic                         brk_on,
  input logic                         soft_rst,
  input logic [31:0]                  ctrl_q,
  input logic [3:0]                   err_q,
  input logic [$clog2(DEPTH+1)-1:0]   tx_level,
  input logic [$clog2(DEPTH+1)-1:0]   rx_level,
  input logic                         rx_push,
  input logic                         rx_full,
  input logic                         tx_busy,
  input logic                         irq
);
  // R2
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |-> !tick);
  // R4
  tx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= DEPTH);
  // R5
  rx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= DEPTH);
  // R11
  brk_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_on |-> !txd);
  // R3
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !brk_on) |-> txd);
  // R13
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctrl_q == 32'h0 && err_q == 4'h0));
  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full && !soft_rst) |=> err_q[0]);
  // R8
  parity_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_q[1]);
  // R10
  irq_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && err_q[0]) |-> irq);
endmodule

bind serial_port_ctrl serial_port_ctrl_chk #(.DEPTH(FIFO_DEPTH), .DIVW(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .div_q(div_q), .txd(txd), .brk_on(brk_on),
  .soft_rst(soft_rst), .ctrl_q(ctrl_q), .err_q(err_q), .tx_level(tx_level),
  .rx_level(rx_level), .rx_push(rx_push), .rx_full(rx_full), .tx_busy(tx_busy), .irq(irq)
);

// File: tb/serial_port_ctrl_test.sv
`timescale 1ns/1ps
module serial_port_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  logic        rxd = 1'b1;
  wire         txd, irq;

  int n_chk = 0, n_err = 0;
  int div_m = 2;
  bit dec_en = 0, brk_mdl = 0;
  logic [7:0] tx_exp[$], tx_got[$], rx_mdl[$];

  always #2.5 clk = ~clk;

  serial_port_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .rxd(rxd), .txd(txd), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  task automatic expect_reg(input logic [4:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    bus_read(a, v);
    check(v === e, tag, v, e);
  endtask

  task automatic hold_bits(input logic lvl, input int bits);
    rxd = lvl;
    repeat (bits * 16 * div_m) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    @(negedge clk);
    hold_bits(1'b0, 1);
    for (int i = 0; i < 8; i++) hold_bits(b[i], 1);
    hold_bits(stop, 1);
    rxd = 1'b1;
  endtask

  // behavioural line decoder on txd
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (dec_en && txd === 1'b0) begin
        repeat (8 * div_m) @(negedge clk);
        if (txd === 1'b0) begin
          for (int i = 0; i < 8; i++) begin
            repeat (16 * div_m) @(negedge clk);
            b[i] = txd;
          end
          repeat (16 * div_m) @(negedge clk);
          check(txd === 1'b1, "R3 stop bit high", {31'h0, txd}, 32'h1);
          tx_got.push_back(b);
        end
      end
    end
  end

  // per-clock comparison of the line against the break model
  always @(negedge clk) begin
    if (rst_n && brk_mdl) check(txd === 1'b0, "R11 line held low", {31'h0, txd}, 32'h0);
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic compare_tx(input string tag);
    check(tx_got.size() == tx_exp.size(), {tag, " count"}, tx_got.size(), tx_exp.size());
    for (int i = 0; i < tx_exp.size() && i < tx_got.size(); i++)
      check(tx_got[i] === tx_exp[i], tag, {24'h0, tx_got[i]}, {24'h0, tx_exp[i]});
    tx_got.delete(); tx_exp.delete();
  endtask

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(irq === 1'b0, "R1 irq after reset", {31'h0, irq}, 32'h0);
    check(txd === 1'b1, "R1 txd after reset", {31'h0, txd}, 32'h1);
    expect_reg(5'h0C, 32'h2060, "R1 status reset");
    expect_reg(5'h08, 32'h0, "R1 control reset");
    expect_reg(5'h10, 32'h0, "R1 divisor reset");
    expect_reg(5'h14, 32'h0, "R1 unmapped offset");
    // R2 divisor width
    bus_write(5'h10, 32'hFFFF_FFFF);
    expect_reg(5'h10, 32'h3FF, "R2 divisor low bits");
    bus_write(5'h10, 32'd2);

    // R3 burst of unlike bytes
    dec_en = 1;
    foreach (tx_exp[i]) ;
    tx_exp = '{8'h3C, 8'hA5, 8'h01};
    foreach (tx_exp[i]) bus_write(5'h04, {24'h0, tx_exp[i]});
    repeat (3 * 160 * div_m + 200) @(negedge clk);
    compare_tx("R3 serial byte");
    expect_reg(5'h0C, 32'h2060, "R4 idle after burst");

    // R4 / R2: fill with tick stopped
    bus_write(5'h10, 32'd0);
    for (int i = 0; i < 33; i++) begin
      bus_write(5'h04, 32'(i * 7 + 1));
      if (i < 32) tx_exp.push_back(8'(i * 7 + 1));
    end
    expect_reg(5'h0C, 32'h0800, "R4 full status");
    repeat (500) @(negedge clk);
    check(txd === 1'b1 && tx_got.size() == 0, "R2 divisor zero holds line", {31'h0, txd}, 32'h1);
    expect_reg(5'h0C, 32'h0800, "R2 nothing drained");
    bus_write(5'h10, 32'd2);
    repeat (32 * 160 * div_m + 300) @(negedge clk);
    compare_tx("R4 drop on full");
    expect_reg(5'h0C, 32'h2060, "R4 drained");
    dec_en = 0;

    // R5 receive clean frames
    rx_mdl = '{8'h55, 8'hA3, 8'h00};
    foreach (rx_mdl[i]) send_frame(rx_mdl[i], 1'b1);
    expect_reg(5'h0C, 32'h2070, "R5 rx ready");
    foreach (rx_mdl[i]) expect_reg(5'h00, {24'h0, rx_mdl[i]}, "R5 rx byte");
    rx_mdl.delete();
    expect_reg(5'h0C, 32'h2060, "R5 rx drained");
    expect_reg(5'h00, 32'h0, "R5 empty read");

    // R6 overrun
    for (int i = 0; i < 33; i++) begin
      send_frame(8'(i ^ 8'h5A), 1'b1);
      if (i < 32) rx_mdl.push_back(8'(i ^ 8'h5A));
    end
    expect_reg(5'h0C, 32'h2071, "R6 overrun flag");
    bus_write(5'h0C, 32'h0);
    expect_reg(5'h0C, 32'h2071, "R9 zero write keeps");
    bus_write(5'h08, 32'h1);
    check(irq === 1'b1, "R10 overrun irq", {31'h0, irq}, 32'h1);
    bus_write(5'h0C, 32'h1);
    expect_reg(5'h0C, 32'h2070, "R9 one clears");
    check(irq === 1'b0, "R10 irq after clear", {31'h0, irq}, 32'h0);
    foreach (rx_mdl[i]) expect_reg(5'h00, {24'h0, rx_mdl[i]}, "R6 kept bytes");
    rx_mdl.delete();
    expect_reg(5'h0C, 32'h2060, "R6 discard of last");

    // R7 framing
    bus_write(5'h08, 32'h4);
    send_frame(8'h5A, 1'b0);
    repeat (2 * 16 * div_m) @(negedge clk);
    expect_reg(5'h0C, 32'h2064, "R7 framing set, no byte");
    check(irq === 1'b1, "R10 framing irq", {31'h0, irq}, 32'h1);
    // R8 break
    @(negedge clk);
    hold_bits(1'b0, 12);
    hold_bits(1'b1, 2);
    expect_reg(5'h0C, 32'h206C, "R8 break set, no byte");
    bus_write(5'h0C, 32'hC);
    expect_reg(5'h0C, 32'h2060, "R9 clear break and framing");

    // R10 ready interrupts
    bus_write(5'h08, 32'h10);
    check(irq === 1'b0, "R10 no rx data", {31'h0, irq}, 32'h0);
    send_frame(8'h81, 1'b1);
    check(irq === 1'b1, "R10 rx ready irq", {31'h0, irq}, 32'h1);
    expect_reg(5'h00, 32'h81, "R5 byte for irq");
    check(irq === 1'b0, "R10 rx irq drops", {31'h0, irq}, 32'h0);
    bus_write(5'h08, 32'h20);
    check(irq === 1'b1, "R10 tx ready irq", {31'h0, irq}, 32'h1);

    // R11 send break
    bus_write(5'h08, 32'h800);
    brk_mdl = 1;
    repeat (100) @(negedge clk);
    expect_reg(5'h08, 32'h800, "R11 control stored");
    brk_mdl = 0;
    bus_write(5'h08, 32'h0);
    repeat (3) @(negedge clk);
    check(txd === 1'b1, "R11 line released", {31'h0, txd}, 32'h1);

    // R12 queue flushes
    bus_write(5'h10, 32'd0);
    for (int i = 0; i < 3; i++) bus_write(5'h04, 32'h77);
    expect_reg(5'h0C, 32'h0020, "R12 tx queue loaded");
    bus_write(5'h08, 32'h8000);
    expect_reg(5'h0C, 32'h2060, "R12 tx flushed");
    expect_reg(5'h08, 32'h0, "R12 flush bit not stored");
    bus_write(5'h10, 32'd2);
    send_frame(8'h12, 1'b1);
    send_frame(8'h34, 1'b1);
    expect_reg(5'h0C, 32'h2070, "R12 rx loaded");
    bus_write(5'h08, 32'h4010);
    expect_reg(5'h0C, 32'h2060, "R12 rx flushed");
    expect_reg(5'h08, 32'h10, "R12 other bits stored");

    // R13 soft reset
    bus_write(5'h08, 32'h83F);
    brk_mdl = 1;
    send_frame(8'h66, 1'b0);
    brk_mdl = 0;
    repeat (2 * 16 * div_m) @(negedge clk);
    expect_reg(5'h0C, 32'h2064, "R13 error before reset");
    bus_write(5'h08, 32'h8000_0000);
    expect_reg(5'h08, 32'h0, "R13 control cleared");
    expect_reg(5'h0C, 32'h2060, "R13 status cleared");
    expect_reg(5'h10, 32'h2, "R13 divisor kept");
    check(irq === 1'b0 && txd === 1'b1, "R13 outputs quiet", {30'h0, irq, txd}, 32'h1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule